// File: doc/BRIEF.md
# Hot-Plug Slot Control Sequencer

This block owns the control register of one hot-pluggable PCI slot and the drivers that follow it: slot power, the bus isolation switch, the slot clock switch, the 64-bit request switch, the slot's 64-bit indication and the slot reset. Software reaches it through a small register port. Address 0 is the 8-bit control register. Address 1 is a status word that reports whether a sequence is running and whether a connect has failed.

Two sequencing modes exist. In manual mode every control bit is copied straight to its output pin. In auto mode the bus bit no longer drives the switch itself. Writing it asks the bus arbiter for an idle bus. Once the grant is held and FRAME and IRDY are both deasserted, the block performs a whole disconnect or connect step. A protection option keeps power off unless the presence-detect inputs report a card, and it blocks a connect when no card is seen.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset the control register reads 0x2D and the status word reads 0. Control register layout: bit 5 power, bit 4 bus (1 = disconnected), bit 3 slot 64-bit indication, bit 2 REQ64 switch, bit 1 clock switch, bit 0 slot reset.
- R2: Control bits 7 and 6 always read 0. Bits 5 to 0 read back the last value stored in them.
- R3: With `auto_mode` low, `bus_off`, `slot_req64`, `req64_on`, `clk_on` and `slot_rst` equal control bits 4, 3, 2, 1 and 0 respectively.
- R4: `pwr_on` equals control bit 5, forced low whenever `protect_en` is high and `detect` is not 2'b00 (a card is present only when both detect inputs are low).
- R5: In auto mode, when no sequence is running, a control write whose bit 4 differs from the present `bus_off` level raises `idle_req` and status bit 0 (busy) from the next cycle on. `bus_off` keeps its level until the sequence ends.
- R6: A running sequence ends at the first clock edge at which `idle_gnt`, `frame_n` and `irdy_n` are all high. From then on `idle_req` and busy are low and the results of the sequence are visible. Until that edge `idle_req` stays high.
- R7: A disconnect (bit 4 written to 1) ends with `bus_off` = 1, `clk_on` = 1, `req64_on` = 0 and power bit 5 cleared, so `pwr_on` = 0. Register bits 5, 2 and 1 read back these values.
- R8: A connect (bit 4 written to 0) ends with `bus_off` = 0.
- R9: A connect that ends while `protect_en` is high and `detect` is not 2'b00 leaves `bus_off` at 1. Control bit 4 then reads 1, and status bit 1 (fault) is set.
- R10: The fault flag stays set until a write to address 1 with data bit 1 set. Setting the flag takes precedence over clearing it in the same cycle.
- R11: In auto mode, while a sequence runs, writes keep control bit 4 unchanged and do not start a new sequence. Bits 5, 3, 2, 1 and 0 are still written.
- R12: In auto mode, a control write whose bit 4 equals the present `bus_off` level starts no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_mode | input | 1 | 1 = auto sequencing, 0 = manual (static) |
| protect_en | input | 1 | Enables the presence-detect interlock (static) |
| addr | input | 1 | 0 = control register, 1 = status word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| detect | input | 2 | Presence-detect inputs; 2'b00 = card present |
| idle_gnt | input | 1 | Bus idle grant from the arbiter |
| frame_n | input | 1 | PCI FRAME, active low |
| irdy_n | input | 1 | PCI IRDY, active low |
| idle_req | output | 1 | Bus idle request to the arbiter |
| pwr_on | output | 1 | Slot power enable |
| bus_off | output | 1 | Bus switch control, 1 = isolated |
| clk_on | output | 1 | Slot clock switch control |
| req64_on | output | 1 | REQ64 switch control |
| slot_req64 | output | 1 | 64-bit slot indication to the card |
| slot_rst | output | 1 | Slot reset |

## Verification
A sequencer stuck in its waiting state shows as `idle_req` and busy staying high one cycle after a grant edge with an idle bus. A sequencer that returns to idle too early shows as `idle_req` falling while the grant is still missing. A wrong target or a wrong completion update appears on `bus_off`, `clk_on`, `req64_on`, `pwr_on` and the control readback in the first cycle after the completing edge. Errors in the fault flag or the bit-4 hold are visible through the next status or control read. The bench compares every output and both read words against its model in every cycle, so any of these faults is seen within one clock.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

    localparam int REG_W  = 8;
    localparam int CTRL_W = 6;

    // Control field layout, bit 5 down to bit 0
    typedef struct packed {
        logic pwr;
        logic bus;
        logic s64;
        logic req64;
        logic clk;
        logic rst;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = ctrl_t'(6'h2D);

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_FAULT_BIT = 1;

    typedef enum logic {SEQ_IDLE, SEQ_WAIT} seq_state_t;

    function automatic logic card_seen(input logic [1:0] det);
        return det == 2'b00;
    endfunction

    function automatic logic bus_quiet(input logic gnt, input logic fr_n, input logic ir_n);
        return gnt & fr_n & ir_n;
    endfunction

endpackage

// File: rtl/hp_seq.sv
module hp_seq
    import hp_slot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic auto_mode,
    input  logic protect_en,
    input  logic card_ok,
    input  logic wr_ctrl,
    input  logic wr_bus,
    input  logic idle_gnt,
    input  logic frame_n,
    input  logic irdy_n,
    output logic busy,
    output logic bus_q,
    output logic disc_done,
    output logic conn_fail
);

    seq_state_t state;
    logic       tgt;
    logic       start;
    logic       go;

    assign start     = auto_mode & wr_ctrl & (state == SEQ_IDLE) & (wr_bus != bus_q);
    assign go        = (state == SEQ_WAIT) & bus_quiet(idle_gnt, frame_n, irdy_n);
    assign disc_done = go & tgt;
    assign conn_fail = go & ~tgt & protect_en & ~card_ok;
    assign busy      = (state == SEQ_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            tgt   <= 1'b0;
            bus_q <= 1'b0;
        end else if (start) begin
            state <= SEQ_WAIT;
            tgt   <= wr_bus;
        end else if (go) begin
            state <= SEQ_IDLE;
            if (tgt)
                bus_q <= 1'b1;
            else if (!conn_fail)
                bus_q <= 1'b0;
        end
    end

    // R6: the request is held until the completing edge
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_quiet(idle_gnt, frame_n, irdy_n)) |=> busy);

    // R5: the bus level moves only on a completing edge
    p_bus_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !go |=> $stable(bus_q));

    // R9: a failed connect leaves the slot isolated
    p_fail_isolated_r9: assert property (@(posedge clk) disable iff (rst)
        conn_fail |=> bus_q);

endmodule

// File: rtl/hp_ctrl_reg.sv
module hp_ctrl_reg
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_ctrl,
    input  logic             we_stat,
    input  logic [REG_W-1:0] wdata,
    input  logic             keep_bus,
    input  logic             disc_done,
    input  logic             conn_fail,
    output ctrl_t            ctrl,
    output logic             fault
);

    ctrl_t nxt;
    logic  fault_clr;

    assign fault_clr = we_stat & wdata[STAT_FAULT_BIT];

    always_comb begin
        nxt = ctrl;
        if (we_ctrl) begin
            nxt = ctrl_t'(wdata[CTRL_W-1:0]);
            if (keep_bus)
                nxt.bus = ctrl.bus;
        end
        if (disc_done) begin
            nxt.pwr   = 1'b0;
            nxt.req64 = 1'b0;
            nxt.clk   = 1'b1;
        end
        if (conn_fail)
            nxt.bus = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= CTRL_RESET;
            fault <= 1'b0;
        end else begin
            ctrl <= nxt;
            if (conn_fail)
                fault <= 1'b1;
            else if (fault_clr)
                fault <= 1'b0;
        end
    end

    // R10: the fault flag is sticky
    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (fault && !fault_clr) |=> fault);

    // R11: bus bit held while a sequence runs
    p_bus_bit_kept_r11: assert property (@(posedge clk) disable iff (rst)
        (keep_bus && !conn_fail) |=> $stable(ctrl.bus));

endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int DET_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_mode,
    input  logic             protect_en,
    input  logic             addr,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic [DET_W-1:0] detect,
    input  logic             idle_gnt,
    input  logic             frame_n,
    input  logic             irdy_n,
    output logic             idle_req,
    output logic             pwr_on,
    output logic             bus_off,
    output logic             clk_on,
    output logic             req64_on,
    output logic             slot_req64,
    output logic             slot_rst
);

    ctrl_t ctrl;
    logic  fault, busy, bus_q, disc_done, conn_fail, card_ok;
    logic  we_ctrl, we_stat;

    assign card_ok = card_seen(detect[1:0]);
    assign we_ctrl = wr_en & (addr == ADDR_CTRL);
    assign we_stat = wr_en & (addr == ADDR_STAT);

    hp_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .auto_mode  (auto_mode),
        .protect_en (protect_en),
        .card_ok    (card_ok),
        .wr_ctrl    (we_ctrl),
        .wr_bus     (wr_data[4]),
        .idle_gnt   (idle_gnt),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .busy       (busy),
        .bus_q      (bus_q),
        .disc_done  (disc_done),
        .conn_fail  (conn_fail)
    );

    hp_ctrl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .we_ctrl    (we_ctrl),
        .we_stat    (we_stat),
        .wdata      (wr_data),
        .keep_bus   (auto_mode & busy),
        .disc_done  (disc_done),
        .conn_fail  (conn_fail),
        .ctrl       (ctrl),
        .fault      (fault)
    );

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_CTRL) begin
            rd_data[CTRL_W-1:0] = ctrl;
        end else begin
            rd_data[STAT_BUSY_BIT]  = busy;
            rd_data[STAT_FAULT_BIT] = fault;
        end
    end

    assign idle_req   = busy;
    assign pwr_on     = ctrl.pwr & (~protect_en | card_ok);
    assign bus_off    = auto_mode ? bus_q : ctrl.bus;
    assign clk_on     = ctrl.clk;
    assign req64_on   = ctrl.req64;
    assign slot_req64 = ctrl.s64;
    assign slot_rst   = ctrl.rst;

    // R4: no power without a card while protected
    p_pwr_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (protect_en && !card_ok) |-> !pwr_on);

    // R2: reserved bits read zero
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_CTRL) |-> (rd_data[7:6] == 2'b00));

    // R7: disconnect result on the pins
    p_disc_pins_r7: assert property (@(posedge clk) disable iff (rst)
        disc_done |=> (bus_off && clk_on && !req64_on && !pwr_on));

endmodule

// File: tb/tb_hp_slot_ctrl.sv
module tb_hp_slot_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       auto_mode = 1'b0, protect_en = 1'b0;
    logic       addr = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] detect = 2'b00;
    logic       idle_gnt = 1'b0, frame_n = 1'b1, irdy_n = 1'b1;
    logic       idle_req, pwr_on, bus_off, clk_on, req64_on, slot_req64, slot_rst;

    int n_chk = 0, n_bad = 0, cyc = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    hp_slot_ctrl dut (
        .clk(clk), .rst(rst), .auto_mode(auto_mode), .protect_en(protect_en),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .detect(detect), .idle_gnt(idle_gnt), .frame_n(frame_n), .irdy_n(irdy_n),
        .idle_req(idle_req), .pwr_on(pwr_on), .bus_off(bus_off), .clk_on(clk_on),
        .req64_on(req64_on), .slot_req64(slot_req64), .slot_rst(slot_rst)
    );

    // reference model built from the requirements
    logic [5:0] m_ctrl;
    logic       m_bus, m_busy, m_fault, m_tgt;

    always @(posedge clk) begin
        logic go, start;
        logic [5:0] n;
        if (rst) begin
            m_ctrl = 6'h2D; m_bus = 0; m_busy = 0; m_fault = 0; m_tgt = 0;
        end else begin
            go    = m_busy && idle_gnt && frame_n && irdy_n;
            start = auto_mode && !m_busy && wr_en && !addr && (wr_data[4] != m_bus);
            n = m_ctrl;
            if (wr_en && !addr) begin
                n = wr_data[5:0];
                if (auto_mode && m_busy) n[4] = m_ctrl[4];
            end
            if (wr_en && addr && wr_data[1]) m_fault = 0;
            if (go) begin
                if (m_tgt) begin
                    m_bus = 1; n[5] = 0; n[2] = 0; n[1] = 1;
                end else if (protect_en && detect != 2'b00) begin
                    m_fault = 1; n[4] = 1;
                end else begin
                    m_bus = 0;
                end
                m_busy = 0;
            end
            if (start) begin
                m_busy = 1; m_tgt = wr_data[4];
            end
            m_ctrl = n;
        end
        cyc++;
    end

    function automatic logic exp_pwr();
        return m_ctrl[5] & (!protect_en | detect == 2'b00);
    endfunction

    function automatic logic [7:0] exp_rd();
        return addr ? {6'b0, m_fault, m_busy} : {2'b00, m_ctrl};
    endfunction

    task automatic cmp(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic check_all();
        cmp("rd_data",    rd_data,    exp_rd());
        cmp("pwr_on",     {7'b0, pwr_on},     {7'b0, exp_pwr()});
        cmp("bus_off",    {7'b0, bus_off},    {7'b0, auto_mode ? m_bus : m_ctrl[4]});
        cmp("idle_req",   {7'b0, idle_req},   {7'b0, m_busy});
        cmp("clk_on",     {7'b0, clk_on},     {7'b0, m_ctrl[1]});
        cmp("req64_on",   {7'b0, req64_on},   {7'b0, m_ctrl[2]});
        cmp("slot_req64", {7'b0, slot_req64}, {7'b0, m_ctrl[3]});
        cmp("slot_rst",   {7'b0, slot_rst},   {7'b0, m_ctrl[0]});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic am, input logic pe);
        rst = 1'b1; auto_mode = am; protect_en = pe;
        idle_gnt = 0; frame_n = 1; irdy_n = 1; wr_en = 0; addr = 0;
        tick(); tick();
        rst = 1'b0;
        tag = "R1";
        addr = 0; tick();
        addr = 1; tick();
        addr = 0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5107));
        @(negedge clk);

        // manual mode, directed
        do_reset(1'b0, 1'b0);
        tag = "R2"; wr(0, 8'hFF); wr(0, 8'hC0); wr(0, 8'h2A);
        tag = "R3"; wr(0, 8'h15); wr(0, 8'h0A);
        tag = "R4"; protect_en = 1; wr(0, 8'h20);
        detect = 2'b01; tick(); detect = 2'b10; tick(); detect = 2'b00; tick();

        // manual mode, random
        for (int m = 0; m < 2; m++) begin
            do_reset(1'b0, m[0]);
            tag = "R3";
            for (int i = 0; i < 400; i++) begin
                wr_en = ($urandom % 3) == 0; addr = $urandom % 2;
                wr_data = $urandom; detect = $urandom;
                idle_gnt = $urandom; frame_n = $urandom; irdy_n = $urandom;
                if (addr) wr_data[1] = 0;
                tick();
            end
            wr_en = 0;
        end

        // auto mode, directed
        do_reset(1'b1, 1'b1);
        detect = 2'b00;
        tag = "R12"; wr(0, 8'h2D); addr = 1; tick(); addr = 0;
        tag = "R5";  idle_gnt = 0; wr(0, 8'h3D); tick();
        tag = "R6";  tick(); idle_gnt = 1; frame_n = 0; tick();
        frame_n = 1; irdy_n = 0; tick();
        tag = "R11"; wr(0, 8'h0A); addr = 1; tick(); addr = 0;
        tag = "R7";  irdy_n = 1; tick(); tick();
        tag = "R8";  idle_gnt = 0; wr(0, 8'h20); tick(); idle_gnt = 1; tick(); tick();
        tag = "R9";  wr(0, 8'h30); idle_gnt = 1; tick();
        detect = 2'b10; idle_gnt = 0; wr(0, 8'h20); addr = 1; tick();
        idle_gnt = 1; tick(); tick(); addr = 0; tick();
        tag = "R10"; addr = 1; wr(1, 8'h01); tick(); wr(1, 8'h02); tick();
        detect = 2'b00; addr = 0; tick();

        // auto mode, random
        for (int m = 0; m < 2; m++) begin
            do_reset(1'b1, m[0]);
            tag = "R6";
            for (int i = 0; i < 3000; i++) begin
                wr_en = ($urandom % 4) == 0; addr = ($urandom % 4) == 0;
                wr_data = $urandom;
                if (($urandom % 8) == 0) detect = $urandom;
                idle_gnt = ($urandom % 3) == 0; frame_n = ($urandom % 4) != 0;
                irdy_n = ($urandom % 4) != 0;
                tick();
            end
            wr_en = 0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule